// File: doc/BRIEF.md
# Prefetch Return Reorder Queue

This block tracks memory prefetches that a processor issues ahead of the point where it needs the data. Each accepted prefetch reserves the next slot of a circular queue. Its address goes to memory at once, tagged with that slot index. Memory may answer the outstanding requests in any order. Every answer is written into the slot named by its tag. The processor consumes results strictly in the order it issued them.

A consume request succeeds only when the oldest reserved slot holds its data. Otherwise the consumer is stalled, and that includes the case where nothing is outstanding. An answer that arrives for the oldest slot in the same cycle as a consume request is passed straight through, so it costs no extra stall cycle. An answer whose tag names a slot that is not waiting for data is dropped, and a sticky error indication is raised.

Top module: `prefetch_reorder_queue`

## Requirements
- R1: After reset, iss_ready is 1, mreq_valid is 0, err_flag is 0 and the queue is empty. The first accepted issue receives tag 0.
- R2: An accepted issue (iss_valid and iss_ready both 1) asserts mreq_valid in the same cycle, with mreq_addr equal to iss_addr and mreq_tag equal to the reserved slot index. Successive issues receive indices 0, 1, ..., 15 and then 0 again.
- R3: Up to DEPTH = 16 prefetches can be outstanding at once. While all 16 slots are reserved, iss_ready is 0, and iss_valid reserves nothing and asserts no mreq_valid.
- R4: A response (mrsp_valid = 1) whose mrsp_tag names a reserved slot still awaiting data stores mrsp_data in that slot. Responses may arrive in any order.
- R5: Results leave in issue order. In a cycle with pop_req = 1 and pop_stall = 0, pop_data carries the data of the oldest outstanding prefetch, and that prefetch is consumed.
- R6: pop_stall is 1 exactly when pop_req is 1 and the oldest slot has no data, which includes an empty queue. A stalled request consumes nothing, and pop_stall is 0 whenever pop_req is 0.
- R7: A valid response for the oldest slot, arriving in the same cycle as pop_req, gives pop_stall = 0 and pop_data = mrsp_data in that cycle. The slot is consumed.
- R8: Consuming frees the slot, and the oldest position advances modulo 16, so freed slots are reserved again. An issue and a consume in the same cycle both take effect. When the queue is full, the issue in such a cycle is refused.
- R9: A response whose tag names a slot that is not reserved, or that already holds data, changes no slot. err_flag goes to 1 on the following clock edge and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Prefetch issue request |
| iss_addr | input | ADDR_W | Prefetch address |
| iss_ready | output | 1 | A free slot exists, so an issue is accepted |
| mreq_valid | output | 1 | Memory request strobe |
| mreq_tag | output | log2(DEPTH) | Slot index sent with the request |
| mreq_addr | output | ADDR_W | Memory request address |
| mrsp_valid | input | 1 | Memory response strobe |
| mrsp_tag | input | log2(DEPTH) | Slot index of the response |
| mrsp_data | input | DATA_W | Response data |
| pop_req | input | 1 | Consume request |
| pop_stall | output | 1 | Consume request cannot complete this cycle |
| pop_data | output | DATA_W | Data of the consumed entry |
| err_flag | output | 1 | Sticky error for a response to a slot that is not waiting |

## Verification
A corrupted allocation or fill flag shows at the ports within a few cycles. It appears as a wrong iss_ready at the full boundary, a stall that never clears, a pop that completes early, or a spurious err_flag. A wrong head or tail pointer shows on the very next issue as an unexpected mreq_tag, or on the next completed pop as data belonging to another prefetch. Misrouted response data therefore surfaces at the first pop of the affected slot, at most 16 pops after the corruption. The sweep scrambles response order with several odd strides across the wrap point, so that any mismatch between slot index and pop order shows.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    RSP_IDLE   = 2'd0,
    RSP_FILL   = 2'd1,
    RSP_REJECT = 2'd2
  } rsp_kind_e;

  function automatic int unsigned idx_width(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pfq_ptrs.sv
module pfq_ptrs #(
  parameter int DEPTH = 16,
  localparam int IDX_W = pfq_pkg::idx_width(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (pop_i) begin
      head_d = (head_q == LAST) ? '0 : head_q + 1'b1;
    end
    if (push_i) begin
      tail_d = (tail_q == LAST) ? '0 : tail_q + 1'b1;
    end
    if (push_i && !pop_i) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop_i && !push_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i);

  a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !pop_i);

  a_r8_count_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/pfq_slots.sv
module pfq_slots #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = pfq_pkg::idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              free_en,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DEPTH-1:0]  alloc_o,
  output logic [DEPTH-1:0]  dval_o,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] store [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic              a_q, a_d, v_q, v_d;
    logic              hit_alloc, hit_fill, hit_free;
    logic [DATA_W-1:0] d_q;

    assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(s));
    assign hit_fill  = fill_en  && (fill_idx  == IDX_W'(s));
    assign hit_free  = free_en  && (free_idx  == IDX_W'(s));

    always_comb begin
      a_d = a_q;
      v_d = v_q;
      if (hit_alloc) a_d = 1'b1;
      if (hit_fill)  v_d = 1'b1;
      if (hit_free) begin
        a_d = 1'b0;
        v_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= 1'b0;
        v_q <= 1'b0;
      end else begin
        a_q <= a_d;
        v_q <= v_d;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_fill) d_q <= fill_data;
    end

    assign alloc_o[s] = a_q;
    assign dval_o[s]  = v_q;
    assign store[s]   = d_q;
  end

  assign rd_data = store[rd_idx];

  a_r3_alloc_only_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !alloc_o[alloc_idx]);

  a_r4_fill_only_waiting_slot: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (alloc_o[fill_idx] && !dval_o[fill_idx]));

  a_r8_free_only_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> alloc_o[free_idx]);

  a_r4_data_needs_reservation: assert property (@(posedge clk) disable iff (!rst_n)
    ((dval_o & ~alloc_o) == '0));

endmodule

// File: rtl/prefetch_reorder_queue.sv
module prefetch_reorder_queue #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = pfq_pkg::idx_width(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [ADDR_W-1:0] iss_addr,
  output logic              iss_ready,
  output logic              mreq_valid,
  output logic [IDX_W-1:0]  mreq_tag,
  output logic [ADDR_W-1:0] mreq_addr,
  input  logic              mrsp_valid,
  input  logic [IDX_W-1:0]  mrsp_tag,
  input  logic [DATA_W-1:0] mrsp_data,
  input  logic              pop_req,
  output logic              pop_stall,
  output logic [DATA_W-1:0] pop_data,
  output logic              err_flag
);

  import pfq_pkg::*;

  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              full;
  logic [DEPTH-1:0]  alloc_vec, dval_vec;
  logic [DATA_W-1:0] head_data;
  logic              issue_fire, pop_fire, fwd, head_ready;
  rsp_kind_e         rsp_kind;
  logic              err_q, err_d;

  assign iss_ready  = !full;
  assign issue_fire = iss_valid && iss_ready;
  assign mreq_valid = issue_fire;
  assign mreq_tag   = tail;
  assign mreq_addr  = iss_addr;

  always_comb begin
    rsp_kind = RSP_IDLE;
    if (mrsp_valid) begin
      rsp_kind = (alloc_vec[mrsp_tag] && !dval_vec[mrsp_tag]) ? RSP_FILL : RSP_REJECT;
    end
  end

  assign fwd        = (rsp_kind == RSP_FILL) && (mrsp_tag == head);
  assign head_ready = dval_vec[head] || fwd;
  assign pop_fire   = pop_req && head_ready;
  assign pop_stall  = pop_req && !head_ready;
  assign pop_data   = dval_vec[head] ? head_data : mrsp_data;

  always_comb begin
    err_d = err_q;
    if (rsp_kind == RSP_REJECT) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_flag = err_q;

  pfq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (issue_fire),
    .pop_i   (pop_fire),
    .head_o  (head),
    .tail_o  (tail),
    .count_o (count),
    .full_o  (full)
  );

  pfq_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (issue_fire),
    .alloc_idx (tail),
    .fill_en   (rsp_kind == RSP_FILL),
    .fill_idx  (mrsp_tag),
    .fill_data (mrsp_data),
    .free_en   (pop_fire),
    .free_idx  (head),
    .rd_idx    (head),
    .alloc_o   (alloc_vec),
    .dval_o    (dval_vec),
    .rd_data   (head_data)
  );

  a_r3_count_matches_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(alloc_vec) == int'(count)));

  a_r6_stall_holds_head: assert property (@(posedge clk) disable iff (!rst_n)
    pop_stall |=> (head == $past(head)));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r5_pop_from_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !pop_stall) |-> alloc_vec[head]);

endmodule

// File: tb/prefetch_reorder_queue_tb_top.sv
`timescale 1ns/1ps
module prefetch_reorder_queue_tb_top;

  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [AW-1:0] iss_addr = '0;
  logic iss_ready, mreq_valid;
  logic [TW-1:0] mreq_tag;
  logic [AW-1:0] mreq_addr;
  logic mrsp_valid = 1'b0;
  logic [TW-1:0] mrsp_tag = '0;
  logic [DW-1:0] mrsp_data = '0;
  logic pop_req = 1'b0;
  logic pop_stall;
  logic [DW-1:0] pop_data;
  logic err_flag;

  always #2.5 clk = ~clk;

  prefetch_reorder_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_ready(iss_ready),
    .mreq_valid(mreq_valid), .mreq_tag(mreq_tag), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag), .mrsp_data(mrsp_data),
    .pop_req(pop_req), .pop_stall(pop_stall), .pop_data(pop_data),
    .err_flag(err_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit m_alloc [DEPTH];
  bit m_fill  [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  logic [AW-1:0] m_addr [DEPTH];
  int hd, tl, cnt;
  bit m_err;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin
      m_alloc[i] = 0; m_fill[i] = 0; m_data[i] = '0; m_addr[i] = '0;
    end
    hd = 0; tl = 0; cnt = 0; m_err = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    iss_valid = 0; mrsp_valid = 0; pop_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    #1;
    chk(iss_ready == 1'b1, "R1 ready", iss_ready, 1);
    chk(mreq_valid == 1'b0, "R1 mreq_valid", mreq_valid, 0);
    chk(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
    chk(mreq_tag == '0, "R1 first tag", mreq_tag, 0);
  endtask

  task automatic step(input bit iv, input logic [AW-1:0] ia, input bit rv,
                      input logic [TW-1:0] rt, input logic [DW-1:0] rd, input bit pr);
    bit e_ready, acc, gd, fwd, pok;
    logic [DW-1:0] e_data;
    @(negedge clk);
    iss_valid = iv; iss_addr = ia;
    mrsp_valid = rv; mrsp_tag = rt; mrsp_data = rd;
    pop_req = pr;
    #1;
    e_ready = (cnt < DEPTH);
    acc = iv && e_ready;
    gd = rv && m_alloc[rt] && !m_fill[rt];
    fwd = gd && (int'(rt) == hd);
    pok = m_fill[hd] || fwd;
    e_data = m_fill[hd] ? m_data[hd] : rd;
    chk(iss_ready == e_ready, "R3 iss_ready", iss_ready, e_ready);
    chk(mreq_valid == acc, "R2 mreq_valid", mreq_valid, acc);
    if (acc) begin
      chk(mreq_tag == TW'(tl), "R2 R8 mreq_tag", mreq_tag, tl);
      chk(mreq_addr == ia, "R2 mreq_addr", mreq_addr, ia);
    end
    if (pr) begin
      chk(pop_stall == !pok, "R6 pop_stall", pop_stall, !pok);
      if (pok) chk(pop_data == e_data, (fwd && !m_fill[hd]) ? "R7 forwarded data" : "R4 R5 pop_data",
                   pop_data, e_data);
    end else begin
      chk(pop_stall == 1'b0, "R6 idle stall", pop_stall, 0);
    end
    @(posedge clk);
    #0.2;
    iss_valid = 0; mrsp_valid = 0; pop_req = 0;
    if (gd) begin m_fill[rt] = 1; m_data[rt] = rd; end
    if (pr && pok) begin
      m_alloc[hd] = 0; m_fill[hd] = 0; hd = (hd + 1) % DEPTH; cnt--;
    end
    if (acc) begin
      m_alloc[tl] = 1; m_addr[tl] = ia; tl = (tl + 1) % DEPTH; cnt++;
    end
    if (rv && !gd) m_err = 1;
    chk(err_flag == m_err, "R9 err_flag", err_flag, m_err);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    // R6: consume on empty queue stalls
    step(0, '0, 0, '0, '0, 1);
    // R7: forward on a single outstanding entry, moves head off zero
    step(1, 32'h0000_4000, 0, '0, '0, 0);
    step(0, '0, 1, TW'(hd), 32'h1234_5678, 1);

    // R3 R4 R5 R8: full fill, scrambled responses, several strides across wrap
    for (int r = 0; r < 4; r++) begin
      int perm;
      perm = 2 * r + 5;
      for (int i = 0; i < DEPTH; i++) step(1, AW'(32'h1000 + r * 32'h100 + i * 4), 0, '0, '0, 0);
      step(1, 32'hDEAD_BEEF, 0, '0, '0, 0);
      step(0, '0, 0, '0, '0, 1);
      for (int i = 0; i < DEPTH; i++) begin
        int t;
        t = (i * perm + r * 3) % DEPTH;
        step(0, '0, 1, TW'(t), m_addr[t] * 3 + DW'(r), (i % 3) == 2);
      end
      while (cnt > 0) step(0, '0, 0, '0, '0, 1);
    end

    // R7: forwarding with later entries already filled
    for (int i = 0; i < 3; i++) step(1, AW'(32'h8000 + i), 0, '0, '0, 0);
    step(0, '0, 1, TW'((hd + 2) % DEPTH), 32'hCAFE_0002, 1);
    step(0, '0, 1, TW'(hd), 32'hCAFE_0000, 1);
    step(0, '0, 1, TW'(hd), 32'hCAFE_0001, 1);
    step(0, '0, 0, '0, '0, 1);

    // R9: response to a slot that is not reserved
    step(0, '0, 1, TW'((hd + 5) % DEPTH), 32'hBAD0_0001, 0);
    step(0, '0, 0, '0, '0, 1);
    // R9: duplicate response ignored, first data kept
    step(1, 32'h9000, 0, '0, '0, 0);
    step(0, '0, 1, TW'(hd), 32'h1111_1111, 0);
    step(0, '0, 1, TW'(hd), 32'h2222_2222, 0);
    step(0, '0, 0, '0, '0, 1);

    // R8: issue and consume together, at full and just below full
    for (int i = 0; i < DEPTH; i++) step(1, AW'(32'hA000 + i), 0, '0, '0, 0);
    for (int i = 0; i < DEPTH; i++) step(0, '0, 1, TW'((hd + i) % DEPTH), DW'(32'h5000 + i), 0);
    step(1, 32'hB000, 0, '0, '0, 1);
    step(1, 32'hB001, 0, '0, '0, 1);
    step(1, 32'hB002, 0, '0, '0, 1);
    while (cnt > 0) begin
      if (!m_fill[hd]) step(0, '0, 1, TW'(hd), DW'(32'h7000 + hd), 1);
      else step(0, '0, 0, '0, '0, 1);
    end

    // R1: reset clears the sticky error and the queue
    do_reset();
    step(1, 32'hC000, 0, '0, '0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule